// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a small processor that finishes each instruction in one clock period. It handles nine instructions: five register-to-register operations (add, sub, and, or, set-less-than), word load, word store, branch-if-equal and an absolute jump. The program counter, a 32-entry register file with two read ports and one write port, and word-addressed instruction and data arrays all sit inside the block. Two dedicated adders form PC+4 and the branch target, so the ALU is free for the data operation in every cycle.

Control is split into two levels. A main decoder turns the 6-bit opcode into datapath selects, enables and a 2-bit operation class. An ALU decoder then combines that class with the 6-bit function field to pick one of five 3-bit ALU codes. The testbench preloads the program and data arrays while reset is held. The only outputs are debug views: the current PC, and the register write that the current instruction commits at the next rising edge.

Top module: `sc_core`

## Requirements
- R1: While the synchronous reset input is high, the PC is loaded with 0 at each rising edge and no register write is reported (rf_we_o = 0). The first instruction after reset is fetched from word 0.
- R2: Instruction fields are opcode[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. Opcode 000000 with funct 100000, 100010, 100100 or 100101 writes rs+rt, rs-rt, rs AND rt or rs OR rt into rd. The write is reported on rf_we_o, rf_waddr_o and rf_wdata_o in the same cycle.
- R3: Opcode 000000 with funct 101010 writes 1 into rd when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R4: Opcode 100011 (load) writes the data word at byte address rs + sign-extended imm[15:0] into rt. The data array is indexed by address bits [7:2], and negative offsets are allowed.
- R5: Opcode 101011 (store) writes rt to the data word at rs + sign-extended imm[15:0] and reports no register write. A later load from the same address returns the stored value.
- R6: Opcode 000100 compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended imm shifted left by 2, and backward offsets are allowed. Otherwise the next PC is PC+4. No register is written either way.
- R7: Opcode 000010 sets the next PC to {PC+4[31:28], instr[25:0], 2'b00} and writes no register.
- R8: Register 0 always reads as zero. An instruction whose destination is register 0 reports no write and leaves register 0 at zero.
- R9: Any other opcode writes no register and no memory, and advances the PC by 4. All instructions other than taken branches and jumps also advance the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | High when this instruction writes a register at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |

## Verification
The hardest situations to reach are those where the processor's own earlier results steer its control flow. Examples are a taken branch whose operands came from loads and arithmetic a few instructions earlier, a load whose address needs a negative offset from a computed register, and a backward branch that makes a tight loop. The program is built so that register values come from preloaded data words. It then arranges both an unequal and an equal branch, a store followed by a load of the same word, a write aimed at register 0 and an undefined opcode. A second reset in the middle of the loop shows that the PC returns to word 0 while the data memory keeps its contents.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN = 32;
    localparam int RAW  = 5;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } op_class_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_sel_e;

    typedef struct packed {
        logic      dst_is_rd;
        logic      src_is_imm;
        logic      wb_from_mem;
        logic      reg_wr;
        logic      mem_rd;
        logic      mem_wr;
        logic      is_branch;
        logic      is_jump;
        op_class_e op_class;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode_i,
    output ctrl_t      ctrl_o
);

    always_comb begin
        ctrl_o = '{dst_is_rd: 1'b0, src_is_imm: 1'b0, wb_from_mem: 1'b0,
                   reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                   is_branch: 1'b0, is_jump: 1'b0, op_class: CLS_ADD};
        unique case (opcode_i)
            OPC_RTYPE: begin
                ctrl_o.dst_is_rd = 1'b1;
                ctrl_o.reg_wr    = 1'b1;
                ctrl_o.op_class  = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl_o.src_is_imm  = 1'b1;
                ctrl_o.wb_from_mem = 1'b1;
                ctrl_o.reg_wr      = 1'b1;
                ctrl_o.mem_rd      = 1'b1;
            end
            OPC_STORE: begin
                ctrl_o.src_is_imm = 1'b1;
                ctrl_o.mem_wr     = 1'b1;
            end
            OPC_BEQ: begin
                ctrl_o.is_branch = 1'b1;
                ctrl_o.op_class  = CLS_SUB;
            end
            OPC_JUMP: begin
                ctrl_o.is_jump = 1'b1;
            end
            default: begin
                ctrl_o.op_class = CLS_ADD;
            end
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_core_pkg::*;
(
    input  op_class_e  op_class_i,
    input  logic [5:0] funct_i,
    output alu_sel_e   alu_sel_o
);

    always_comb begin
        alu_sel_o = ALU_ADD;
        unique case (op_class_i)
            CLS_ADD: alu_sel_o = ALU_ADD;
            CLS_SUB: alu_sel_o = ALU_SUB;
            CLS_FUNCT: begin
                unique case (funct_i)
                    FN_ADD:  alu_sel_o = ALU_ADD;
                    FN_SUB:  alu_sel_o = ALU_SUB;
                    FN_AND:  alu_sel_o = ALU_AND;
                    FN_OR:   alu_sel_o = ALU_OR;
                    FN_SLT:  alu_sel_o = ALU_SLT;
                    default: alu_sel_o = ALU_ADD;
                endcase
            end
            default: alu_sel_o = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_sel_e     sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o,
    output logic         zero_o
);

    always_comb begin
        y_o = '0;
        unique case (sel_i)
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            default: y_o = '0;
        endcase
    end

    assign zero_o = (y_o == '0);

endmodule

// File: rtl/sc_regbank.sv
module sc_regbank
    import sc_core_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int NRD   = 2,
    parameter int W     = XLEN
) (
    input  logic                     clk_i,
    input  logic                     we_i,
    input  logic [RAW-1:0]           waddr_i,
    input  logic [W-1:0]             wdata_i,
    input  logic [NRD-1:0][RAW-1:0]  raddr_i,
    output logic [NRD-1:0][W-1:0]    rdata_o
);

    logic [W-1:0] regs_q [NREGS];

    always_ff @(posedge clk_i) begin
        for (int i = 1; i < NREGS; i++) begin
            if (we_i && (waddr_i == RAW'(i))) begin
                regs_q[i] <= wdata_i;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : regs_q[raddr_i[p]];
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int NREGS      = 32
) (
    input  logic            clk_i,
    input  logic            rst_i,
    output logic [XLEN-1:0] pc_o,
    output logic            rf_we_o,
    output logic [RAW-1:0]  rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] = '0;
    end

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0] instr_w, imm_sx;
    logic [5:0]      opcode_w, funct_w;
    logic [RAW-1:0]  rs_w, rt_w, rd_w, waddr_w;
    ctrl_t           ctrl;
    alu_sel_e        alu_sel;
    logic [1:0][RAW-1:0]  rf_raddr;
    logic [1:0][XLEN-1:0] rf_rdata;
    logic [XLEN-1:0] src_b, alu_y, mem_rdata, wdata_w;
    logic            alu_zero, reg_we_w, dmem_we_w;
    logic [DAW-1:0]  dmem_idx;

    assign pc_plus4   = pc_q + XLEN'(4);
    assign instr_w    = imem_q[pc_q[IAW+1:2]];
    assign opcode_w   = instr_w[31:26];
    assign rs_w       = instr_w[25:21];
    assign rt_w       = instr_w[20:16];
    assign rd_w       = instr_w[15:11];
    assign funct_w    = instr_w[5:0];
    assign imm_sx     = {{16{instr_w[15]}}, instr_w[15:0]};
    assign br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr_w[25:0], 2'b00};

    sc_main_dec u_main_dec (
        .opcode_i (opcode_w),
        .ctrl_o   (ctrl)
    );

    sc_alu_dec u_alu_dec (
        .op_class_i (ctrl.op_class),
        .funct_i    (funct_w),
        .alu_sel_o  (alu_sel)
    );

    assign rf_raddr[0] = rs_w;
    assign rf_raddr[1] = rt_w;

    sc_regbank #(.NREGS(NREGS), .NRD(2), .W(XLEN)) u_regbank (
        .clk_i   (clk_i),
        .we_i    (reg_we_w),
        .waddr_i (waddr_w),
        .wdata_i (wdata_w),
        .raddr_i (rf_raddr),
        .rdata_o (rf_rdata)
    );

    assign src_b = ctrl.src_is_imm ? imm_sx : rf_rdata[1];

    sc_alu #(.W(XLEN)) u_alu (
        .sel_i  (alu_sel),
        .a_i    (rf_rdata[0]),
        .b_i    (src_b),
        .y_o    (alu_y),
        .zero_o (alu_zero)
    );

    assign dmem_idx  = alu_y[DAW+1:2];
    assign mem_rdata = ctrl.mem_rd ? dmem_q[dmem_idx] : '0;
    assign dmem_we_w = ctrl.mem_wr && !rst_i;

    always_ff @(posedge clk_i) begin
        if (dmem_we_w) begin
            dmem_q[dmem_idx] <= rf_rdata[1];
        end
    end

    assign waddr_w  = ctrl.dst_is_rd ? rd_w : rt_w;
    assign wdata_w  = ctrl.wb_from_mem ? mem_rdata : alu_y;
    assign reg_we_w = ctrl.reg_wr && (waddr_w != '0) && !rst_i;

    always_comb begin
        if (ctrl.is_jump) begin
            pc_next = jmp_target;
        end else if (ctrl.is_branch && alu_zero) begin
            pc_next = br_target;
        end else begin
            pc_next = pc_plus4;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_o       = pc_q;
    assign rf_we_o    = reg_we_w;
    assign rf_waddr_o = waddr_w;
    assign rf_wdata_o = wdata_w;

    logic unused_bits;
    assign unused_bits = ^{instr_w[10:6], pc_q[1:0], pc_q[XLEN-1:IAW+2],
                           alu_y[1:0], alu_y[XLEN-1:DAW+2]};

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic            clk_i,
    input logic            rst_i,
    input logic [XLEN-1:0] pc_o,
    input logic            rf_we_o,
    input logic [RAW-1:0]  rf_waddr_o,
    input logic [5:0]      opcode,
    input logic            mem_we,
    input logic [25:0]     jfield
);

    logic            prev_rst_q;
    logic [XLEN-1:0] pc4_w, jt_w;

    always_ff @(posedge clk_i) prev_rst_q <= rst_i;

    assign pc4_w = pc_o + XLEN'(4);
    assign jt_w  = {pc4_w[31:28], jfield, 2'b00};

    AST_RESET_PC: assert property (@(posedge clk_i) disable iff (rst_i)
        prev_rst_q |-> (pc_o == '0)); // R1
    AST_PC_ALIGNED: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_o[1:0] == 2'b00); // R6
    AST_NO_ZERO_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        rf_we_o |-> (rf_waddr_o != '0)); // R8
    AST_WRITE_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
        rf_we_o |-> (opcode == OPC_RTYPE || opcode == OPC_LOAD)); // R9
    AST_STORE_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_we |-> (opcode == OPC_STORE && !rf_we_o)); // R5
    AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (rst_i)
        (opcode != OPC_BEQ && opcode != OPC_JUMP) |=> (pc_o == $past(pc4_w))); // R9
    AST_JUMP_PC: assert property (@(posedge clk_i) disable iff (rst_i)
        (opcode == OPC_JUMP) |=> (pc_o == $past(jt_w))); // R7

endmodule

bind sc_core sc_core_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pc_o       (pc_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .opcode     (opcode_w),
    .mem_we     (dmem_we_w),
    .jfield     (instr_w[25:0])
);

// File: tb/sc_core_tb.sv
module sc_core_tb;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] prog [64];
    logic [31:0] mreg [32];
    logic [31:0] mdm  [64];
    logic [31:0] pc_m;
    string       prev_tag;

    always #4 clk_i = ~clk_i;

    sc_core u_dut (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o)
    );

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        logic [31:0] ins, a, b, imm, addr, npc, ed;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, ea;
        logic        ew, known;
        string       tag;
        ins = prog[pc_m[7:2]];
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
        imm = {{16{ins[15]}}, ins[15:0]};
        a = mreg[rs]; b = mreg[rt];
        addr = a + imm;
        npc = pc_m + 32'd4;
        ew = 1'b0; ea = '0; ed = '0; known = 1'b1;
        tag = "R9";
        chk(prev_tag, "pc", pc_o, pc_m);
        case (op)
            6'b000000: begin
                tag = "R2";
                case (fn)
                    6'b100000: ed = a + b;
                    6'b100010: ed = a - b;
                    6'b100100: ed = a & b;
                    6'b100101: ed = a | b;
                    6'b101010: begin ed = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
                    default:   known = 1'b0;
                endcase
                if (rd == 5'd0) tag = "R8";
                ew = known && (rd != 5'd0); ea = rd;
            end
            6'b100011: begin tag = "R4"; ed = mdm[addr[7:2]]; ew = (rt != 5'd0); ea = rt; end
            6'b101011: tag = "R5";
            6'b000100: begin tag = "R6"; if (a == b) npc = pc_m + 32'd4 + {imm[29:0], 2'b00}; end
            6'b000010: begin tag = "R7"; npc = {npc[31:28], ins[25:0], 2'b00}; end
            default:   tag = "R9";
        endcase
        chk(tag, "rf_we", {31'd0, rf_we_o}, {31'd0, ew});
        if (ew) begin
            chk(tag, "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, ea});
            chk(tag, "rf_wdata", rf_wdata_o, ed);
            mreg[ea] = ed;
        end
        if (op == 6'b101011) mdm[addr[7:2]] = b;
        pc_m = npc;
        prev_tag = tag;
    endtask

    task automatic run(int n);
        pc_m = '0;
        prev_tag = "R1";
        for (int c = 0; c < n; c++) begin
            #1;
            step();
            @(negedge clk_i);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin prog[i] = '0; mdm[i] = '0; end
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        prog[0]  = enc_i(6'b100011, 5'd0, 5'd1, 16'd0);
        prog[1]  = enc_i(6'b100011, 5'd0, 5'd2, 16'd4);
        prog[2]  = enc_i(6'b100011, 5'd0, 5'd3, 16'd8);
        prog[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100000);
        prog[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'b100010);
        prog[5]  = enc_r(5'd3, 5'd1, 5'd6, 6'b100100);
        prog[6]  = enc_r(5'd3, 5'd2, 5'd7, 6'b100101);
        prog[7]  = enc_r(5'd2, 5'd1, 5'd8, 6'b101010);
        prog[8]  = enc_r(5'd1, 5'd2, 5'd9, 6'b101010);
        prog[9]  = enc_r(5'd1, 5'd1, 5'd0, 6'b100000);
        prog[10] = enc_r(5'd0, 5'd1, 5'd10, 6'b100000);
        prog[11] = enc_i(6'b101011, 5'd0, 5'd4, 16'd16);
        prog[12] = enc_i(6'b100011, 5'd0, 5'd11, 16'd16);
        prog[13] = enc_i(6'b000100, 5'd1, 5'd2, 16'd5);
        prog[14] = enc_i(6'b000100, 5'd1, 5'd10, 16'd2);
        prog[15] = enc_r(5'd1, 5'd1, 5'd12, 6'b100000);
        prog[16] = enc_r(5'd1, 5'd1, 5'd13, 6'b100000);
        prog[17] = enc_i(6'b100011, 5'd4, 5'd14, 16'hFFFC);
        prog[18] = enc_i(6'b111111, 5'd1, 5'd1, 16'd4);
        prog[19] = {6'b000010, 26'd22};
        prog[20] = enc_r(5'd1, 5'd1, 5'd15, 6'b100000);
        prog[21] = enc_r(5'd1, 5'd1, 5'd16, 6'b100000);
        prog[22] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);
        mdm[0] = 32'd7;
        mdm[1] = 32'hFFFF_FFFD;
        mdm[2] = 32'h0F0F_00FF;
        #1;
        for (int i = 0; i < 64; i++) begin
            u_dut.imem_q[i] = prog[i];
            u_dut.dmem_q[i] <= mdm[i];
        end
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        chk("R1", "pc in reset", pc_o, 32'd0);
        chk("R1", "rf_we in reset", {31'd0, rf_we_o}, 32'd0);
        rst_i = 1'b0;
        run(30);
        rst_i = 1'b1;
        repeat (2) @(negedge clk_i);
        chk("R1", "pc in second reset", pc_o, 32'd0);
        chk("R1", "rf_we in second reset", {31'd0, rf_we_o}, 32'd0);
        rst_i = 1'b0;
        run(30);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule